// File: doc/BRIEF.md
# Programmable CPU Address Window Decoder

This block holds a bank of software-programmed address windows and uses them to steer each 36-bit CPU physical address to a device target. Each window has an enable, a 4-bit target ID, an 8-bit attribute, a size that is a multiple of 64 KB, and a 36-bit base. A lookup is purely combinational. It reports whether the address hit, the target and attribute of the winning window, and a translated address. When two or more windows claim the same address, it also raises a flag.

The first eight windows can translate: they carry a remap value that replaces the upper address bits covered by the window, while the offset bits pass through from the request. The remaining twelve windows have only control and base registers, and they forward the address unchanged. Software reaches all the windows through a word-wide register port. Writes take effect at a clock edge and reads are combinational. The two window groups sit at different strides, with a 16-byte gap between them.

Top module: `cwd_addr_decoder`

## Requirements
- R1: Control register: bit 0 is the enable, bits 7:4 are the target ID, bits 15:8 are the attribute and bits 31:16 are the size field. Bits 3:1 read as zero; the other bits read back as written.
- R2: Base register: bits 31:16 supply address bits 31:16 of the window base and bits 3:0 supply address bits 35:32. The register reads back in that layout, with all other bits zero.
- R3: A window covers (size field × 64 KB + 64 KB) bytes. A request hits when the window is enabled and every request bit from 35 to 16 that is not set in the size field (size field bit k corresponds to address bit 16+k, and bits 35:32 are always compared) equals the base.
- R4: Windows 0 to 7 sit at offset window×0x10, with control at +0x0, base at +0x4, remap-low at +0x8 and remap-high at +0xC. Windows 8 to 19 sit at 0x90 + (window−8)×0x8, with control at +0x0 and base at +0x4.
- R5: Offsets 0x80 to 0x8F, offsets from 0xF0 upward, and offsets not aligned to a word read as zero. Writes to them change no window.
- R6: For windows 0 to 7, remap-low bits 31:16 supply translated address bits 31:16 and remap-high bits 3:0 supply bits 35:32. The translated address takes remap bits where the base is compared and request bits elsewhere, including bits 15:0.
- R7: Writing a remappable window's base register also loads its remap with that base, so the translation is the identity until a remap register is written. Windows 8 to 19 always translate to the request address.
- R8: A window with enable 0 never hits. Writing zero, or any value with bit 0 clear, to a control register disables that window.
- R9: When several enabled windows hit, the lowest-numbered one supplies target, attribute and translated address, and the multi-hit output is 1. With exactly one hit, the multi-hit output is 0.
- R10: When no window hits, the hit, target, attribute, translated address and multi-hit outputs are all zero.
- R11: After reset every window is disabled and every register reads zero.
- R12: A register write changes lookup results only after the clock edge that captures it. A lookup in the same cycle as the write still sees the old configuration.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr_en | input | 1 | Register write strobe |
| cfg_addr | input | 8 | Register byte offset |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data for cfg_addr (combinational) |
| req_addr | input | 36 | Lookup request address |
| hit | output | 1 | Some enabled window matched |
| hit_target | output | 4 | Target ID of winning window |
| hit_attr | output | 8 | Attribute of winning window |
| xlat_addr | output | 36 | Translated address |
| multi_hit | output | 1 | Two or more windows matched |

## Verification
Two functions can fall in the same cycle: a register write and a combinational lookup. The bench provokes this by driving a control write that disables the lowest-numbered of two overlapping windows, while the request address points into the overlap. It checks the outputs once before the capturing edge, where the old winner and multi-hit must still show. It checks them again after the edge, where the higher window must win alone. Writes to the hole, to misaligned offsets and to offsets past the map are likewise followed by lookups, which must be unchanged.

// File: rtl/cwd_pkg.sv
package cwd_pkg;

    localparam int ADDR_W  = 36;
    localparam int GRAN_W  = 16;
    localparam int FIELD_W = ADDR_W - GRAN_W;
    localparam int SIZE_W  = 16;
    localparam int HI_W    = FIELD_W - SIZE_W;
    localparam int TGT_W   = 4;
    localparam int ATTR_W  = 8;
    localparam int DATA_W  = 32;
    localparam int IDX_W   = 8;

    typedef struct packed {
        logic               en;
        logic [TGT_W-1:0]   tgt;
        logic [ATTR_W-1:0]  attr;
        logic [SIZE_W-1:0]  size;
        logic [FIELD_W-1:0] base;
    } win_cfg_t;

    typedef enum logic [1:0] {
        K_CTRL = 2'd0,
        K_BASE = 2'd1,
        K_RMLO = 2'd2,
        K_RMHI = 2'd3
    } reg_kind_t;

    typedef struct packed {
        logic             valid;
        logic [IDX_W-1:0] win;
        reg_kind_t        kind;
    } reg_sel_t;

    typedef struct packed {
        logic               hit;
        logic [TGT_W-1:0]   tgt;
        logic [ATTR_W-1:0]  attr;
        logic [ADDR_W-1:0]  xlat;
    } match_t;

    function automatic reg_sel_t decode_off(input int unsigned off,
                                            input int unsigned n_win,
                                            input int unsigned n_rmp);
        reg_sel_t    s;
        int unsigned lo_span;
        int unsigned hi_base;
        int unsigned hi_end;
        lo_span = n_rmp * 16;
        hi_base = lo_span + 16;
        hi_end  = hi_base + (n_win - n_rmp) * 8;
        s = '0;
        if ((off % 4) == 0) begin
            if (off < lo_span) begin
                s.valid = 1'b1;
                s.win   = IDX_W'(off / 16);
                s.kind  = reg_kind_t'(2'((off % 16) / 4));
            end else if (off >= hi_base && off < hi_end) begin
                s.valid = 1'b1;
                s.win   = IDX_W'(n_rmp + (off - hi_base) / 8);
                s.kind  = reg_kind_t'(2'(((off - hi_base) % 8) / 4));
            end
        end
        return s;
    endfunction

    function automatic logic [FIELD_W-1:0] cmp_mask(input logic [SIZE_W-1:0] sz);
        return {{HI_W{1'b1}}, ~sz};
    endfunction

endpackage

// File: rtl/cwd_regfile.sv
module cwd_regfile
    import cwd_pkg::*;
#(
    parameter int NUM_WIN   = 20,
    parameter int NUM_REMAP = 8,
    parameter int REG_AW    = 8
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                wr_en,
    input  logic [REG_AW-1:0]   addr,
    input  logic [DATA_W-1:0]   wdata,
    output logic [DATA_W-1:0]   rdata,
    output win_cfg_t            cfg [NUM_WIN],
    output logic [FIELD_W-1:0]  rmp [NUM_REMAP]
);

    localparam int PAD_B = DATA_W - SIZE_W - HI_W;

    reg_sel_t sel;
    assign sel = decode_off(32'(addr), NUM_WIN, NUM_REMAP);

    for (genvar i = 0; i < NUM_WIN; i++) begin : g_win
        logic wsel;
        assign wsel = wr_en && sel.valid && (sel.win == IDX_W'(i));

        always_ff @(posedge clk) begin
            if (rst) begin
                cfg[i] <= '0;
            end else if (wsel) begin
                case (sel.kind)
                    K_CTRL: begin
                        cfg[i].en   <= wdata[0];
                        cfg[i].tgt  <= wdata[7:4];
                        cfg[i].attr <= wdata[15:8];
                        cfg[i].size <= wdata[31:16];
                    end
                    K_BASE: cfg[i].base <= {wdata[HI_W-1:0], wdata[DATA_W-1:GRAN_W]};
                    default: ;
                endcase
            end
        end

        if (i < NUM_REMAP) begin : g_rmp
            always_ff @(posedge clk) begin
                if (rst) begin
                    rmp[i] <= '0;
                end else if (wsel) begin
                    case (sel.kind)
                        K_BASE: rmp[i] <= {wdata[HI_W-1:0], wdata[DATA_W-1:GRAN_W]};
                        K_RMLO: rmp[i][SIZE_W-1:0] <= wdata[DATA_W-1:GRAN_W];
                        K_RMHI: rmp[i][FIELD_W-1:SIZE_W] <= wdata[HI_W-1:0];
                        default: ;
                    endcase
                end
            end
        end
    end

    always_comb begin
        rdata = '0;
        if (sel.valid) begin
            for (int i = 0; i < NUM_WIN; i++) begin
                if (sel.win == IDX_W'(i)) begin
                    case (sel.kind)
                        K_CTRL: rdata = {cfg[i].size, cfg[i].attr, cfg[i].tgt, 3'b000, cfg[i].en};
                        K_BASE: rdata = {cfg[i].base[SIZE_W-1:0], {PAD_B{1'b0}},
                                         cfg[i].base[FIELD_W-1:SIZE_W]};
                        default: ;
                    endcase
                end
            end
            for (int j = 0; j < NUM_REMAP; j++) begin
                if (sel.win == IDX_W'(j)) begin
                    case (sel.kind)
                        K_RMLO: rdata = {rmp[j][SIZE_W-1:0], {GRAN_W{1'b0}}};
                        K_RMHI: rdata = {{(DATA_W-HI_W){1'b0}}, rmp[j][FIELD_W-1:SIZE_W]};
                        default: ;
                    endcase
                end
            end
        end
    end

endmodule

// File: rtl/cwd_win_match.sv
module cwd_win_match
    import cwd_pkg::*;
#(
    parameter int NUM_WIN   = 20,
    parameter int NUM_REMAP = 8
) (
    input  logic [ADDR_W-1:0]  req,
    input  win_cfg_t           cfg [NUM_WIN],
    input  logic [FIELD_W-1:0] rmp [NUM_REMAP],
    output match_t             m   [NUM_WIN]
);

    for (genvar i = 0; i < NUM_WIN; i++) begin : g_m
        logic [FIELD_W-1:0] mask;
        logic [FIELD_W-1:0] upper;
        assign mask  = cmp_mask(cfg[i].size);
        assign upper = req[ADDR_W-1:GRAN_W];

        assign m[i].hit  = cfg[i].en && (((upper ^ cfg[i].base) & mask) == '0);
        assign m[i].tgt  = cfg[i].tgt;
        assign m[i].attr = cfg[i].attr;

        if (i < NUM_REMAP) begin : g_xl
            assign m[i].xlat = {(rmp[i] & mask) | (upper & ~mask), req[GRAN_W-1:0]};
        end else begin : g_id
            assign m[i].xlat = req;
        end
    end

endmodule

// File: rtl/cwd_prio_sel.sv
module cwd_prio_sel
    import cwd_pkg::*;
#(
    parameter int NUM_WIN = 20
) (
    input  match_t m [NUM_WIN],
    output match_t win,
    output logic   multi
);

    always_comb begin
        logic found;
        found = 1'b0;
        multi = 1'b0;
        win   = '0;
        for (int i = 0; i < NUM_WIN; i++) begin
            if (m[i].hit) begin
                if (!found) win = m[i];
                else        multi = 1'b1;
                found = 1'b1;
            end
        end
    end

endmodule

// File: rtl/cwd_addr_decoder.sv
module cwd_addr_decoder
    import cwd_pkg::*;
#(
    parameter int NUM_WIN   = 20,
    parameter int NUM_REMAP = 8,
    parameter int REG_AW    = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_wr_en,
    input  logic [REG_AW-1:0] cfg_addr,
    input  logic [31:0]       cfg_wdata,
    output logic [31:0]       cfg_rdata,
    input  logic [35:0]       req_addr,
    output logic              hit,
    output logic [3:0]        hit_target,
    output logic [7:0]        hit_attr,
    output logic [35:0]       xlat_addr,
    output logic              multi_hit
);

    win_cfg_t           cfg [NUM_WIN];
    logic [FIELD_W-1:0] rmp [NUM_REMAP];
    match_t             mt  [NUM_WIN];
    match_t             best;

    cwd_regfile #(.NUM_WIN(NUM_WIN), .NUM_REMAP(NUM_REMAP), .REG_AW(REG_AW)) u_regs (
        .clk   (clk),
        .rst   (rst),
        .wr_en (cfg_wr_en),
        .addr  (cfg_addr),
        .wdata (cfg_wdata),
        .rdata (cfg_rdata),
        .cfg   (cfg),
        .rmp   (rmp)
    );

    cwd_win_match #(.NUM_WIN(NUM_WIN), .NUM_REMAP(NUM_REMAP)) u_match (
        .req (req_addr),
        .cfg (cfg),
        .rmp (rmp),
        .m   (mt)
    );

    cwd_prio_sel #(.NUM_WIN(NUM_WIN)) u_prio (
        .m     (mt),
        .win   (best),
        .multi (multi_hit)
    );

    assign hit        = best.hit;
    assign hit_target = best.tgt;
    assign hit_attr   = best.attr;
    assign xlat_addr  = best.xlat;

endmodule

// File: rtl/cwd_checker.sv
module cwd_checker #(
    parameter int NUM_WIN   = 20,
    parameter int NUM_REMAP = 8,
    parameter int REG_AW    = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              cfg_wr_en,
    input logic [REG_AW-1:0] cfg_addr,
    input logic [31:0]       cfg_wdata,
    input logic [31:0]       cfg_rdata,
    input logic [35:0]       req_addr,
    input logic              hit,
    input logic [3:0]        hit_target,
    input logic [7:0]        hit_attr,
    input logic [35:0]       xlat_addr,
    input logic              multi_hit
);

    localparam int HOLE_LO = NUM_REMAP * 16;
    localparam int HOLE_HI = HOLE_LO + 16;

    logic in_hole;
    assign in_hole = (32'(cfg_addr) >= HOLE_LO) && (32'(cfg_addr) < HOLE_HI);

    AST_MISS_OUTPUTS_ZERO: assert property (@(posedge clk) disable iff (rst)
        !hit |-> (hit_target == '0 && hit_attr == '0 && xlat_addr == '0 && !multi_hit)); // R10

    AST_MULTI_NEEDS_HIT: assert property (@(posedge clk) disable iff (rst)
        multi_hit |-> hit); // R9

    AST_OFFSET_PASSES: assert property (@(posedge clk) disable iff (rst)
        hit |-> (xlat_addr[15:0] == req_addr[15:0])); // R6

    AST_HOLE_READS_ZERO: assert property (@(posedge clk) disable iff (rst)
        in_hole |-> (cfg_rdata == '0)); // R5

    AST_EMPTY_AFTER_RESET: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> !hit); // R11

    AST_CTRL_ZERO_STICKS: assert property (@(posedge clk) disable iff (rst)
        ($past(cfg_wr_en && cfg_addr == '0 && cfg_wdata == '0) && cfg_addr == '0)
            |-> (cfg_rdata == '0)); // R8

endmodule

bind cwd_addr_decoder cwd_checker #(
    .NUM_WIN(NUM_WIN), .NUM_REMAP(NUM_REMAP), .REG_AW(REG_AW)
) u_chk (
    .clk(clk), .rst(rst), .cfg_wr_en(cfg_wr_en), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .req_addr(req_addr),
    .hit(hit), .hit_target(hit_target), .hit_attr(hit_attr),
    .xlat_addr(xlat_addr), .multi_hit(multi_hit)
);

// File: tb/cwd_addr_decoder_tb_top.sv
module cwd_addr_decoder_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_wr_en = 1'b0;
    logic [7:0]  cfg_addr = '0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic [35:0] req_addr = '0;
    logic        hit;
    logic [3:0]  hit_target;
    logic [7:0]  hit_attr;
    logic [35:0] xlat_addr;
    logic        multi_hit;

    int nchk = 0;
    int nfail = 0;

    always #2.5 clk = ~clk;

    cwd_addr_decoder dut_i (
        .clk(clk), .rst(rst), .cfg_wr_en(cfg_wr_en), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .req_addr(req_addr),
        .hit(hit), .hit_target(hit_target), .hit_attr(hit_attr),
        .xlat_addr(xlat_addr), .multi_hit(multi_hit)
    );

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        cfg_wr_en = 1'b1;
        cfg_addr  = a;
        cfg_wdata = d;
        @(negedge clk);
        cfg_wr_en = 1'b0;
    endtask

    task automatic rd_chk(input string tag, input logic [7:0] a, input logic [31:0] exp);
        cfg_addr = a;
        #1;
        check(tag, 64'(cfg_rdata), 64'(exp));
    endtask

    task automatic look(input string tag, input logic [35:0] a, input logic eh,
                        input logic [3:0] et, input logic [7:0] ea,
                        input logic [35:0] ex, input logic em);
        req_addr = a;
        #1;
        check({tag, " hit"},   64'(hit),        64'(eh));
        check({tag, " tgt"},   64'(hit_target), 64'(et));
        check({tag, " attr"},  64'(hit_attr),   64'(ea));
        check({tag, " xlat"},  64'(xlat_addr),  64'(ex));
        check({tag, " multi"}, 64'(multi_hit),  64'(em));
    endtask

    task automatic t_reset;
        rd_chk("R11 ctrl0 after reset", 8'h00, 32'h0);
        rd_chk("R11 base8 after reset", 8'h94, 32'h0);
        look("R11 empty lookup", 36'h0_0000_0000, 0, 0, 0, 0, 0);
    endtask

    task automatic t_remap_window;
        wr(8'h00, 32'h000F_A531);
        wr(8'h04, 32'h2340_0001);
        rd_chk("R1 ctrl0 readback", 8'h00, 32'h000F_A531);
        rd_chk("R2 base0 readback", 8'h04, 32'h2340_0001);
        look("R3 R7 win0 identity", 36'h1_234A_BCDE, 1, 4'h3, 8'hA5, 36'h1_234A_BCDE, 0);
        look("R3 win0 above top",   36'h1_2350_0000, 0, 0, 0, 0, 0);
        look("R3 win0 high bits",   36'h0_234A_BCDE, 0, 0, 0, 0, 0);
        wr(8'h08, 32'h5550_0000);
        wr(8'h0C, 32'h0000_0002);
        rd_chk("R4 R6 remap lo readback", 8'h08, 32'h5550_0000);
        rd_chk("R4 R6 remap hi readback", 8'h0C, 32'h0000_0002);
        look("R6 win0 translated", 36'h1_234A_BCDE, 1, 4'h3, 8'hA5, 36'h2_555A_BCDE, 0);
        wr(8'h04, 32'h2340_0001);
        rd_chk("R7 remap lo reloaded", 8'h08, 32'h2340_0000);
        rd_chk("R7 remap hi reloaded", 8'h0C, 32'h0000_0001);
        look("R7 identity again", 36'h1_234A_BCDE, 1, 4'h3, 8'hA5, 36'h1_234A_BCDE, 0);
    endtask

    task automatic t_upper_group;
        wr(8'h90, 32'h0000_5581);
        wr(8'h94, 32'h3000_0000);
        look("R4 win8 hit", 36'h0_3000_0010, 1, 4'h8, 8'h55, 36'h0_3000_0010, 0);
        wr(8'hE8, 32'h0003_0F91);
        wr(8'hEC, 32'hC000_000F);
        rd_chk("R4 win19 base readback", 8'hEC, 32'hC000_000F);
        look("R3 win19 last byte", 36'hF_C003_FFFF, 1, 4'h9, 8'h0F, 36'hF_C003_FFFF, 0);
        look("R3 win19 past end",  36'hF_C004_0000, 0, 0, 0, 0, 0);
        wr(8'h70, 32'h0000_2261);
        wr(8'h74, 32'h1000_0000);
        wr(8'h78, 32'h2000_0000);
        look("R6 win7 translated", 36'h0_1000_0042, 1, 4'h6, 8'h22, 36'h0_2000_0042, 0);
    endtask

    task automatic t_overlap;
        wr(8'hA0, 32'h0000_1C71);
        wr(8'hA4, 32'h8000_0000);
        rd_chk("R1 win10 ctrl readback", 8'hA0, 32'h0000_1C71);
        look("R7 win10 alone", 36'h0_8000_1234, 1, 4'h7, 8'h1C, 36'h0_8000_1234, 0);
        wr(8'h30, 32'h0001_E041);
        wr(8'h34, 32'h8000_0000);
        look("R9 overlap lowest wins", 36'h0_8000_1234, 1, 4'h4, 8'hE0, 36'h0_8000_1234, 1);
        look("R9 single hit no multi", 36'h0_8001_0004, 1, 4'h4, 8'hE0, 36'h0_8001_0004, 0);
    endtask

    task automatic t_hole;
        wr(8'h80, 32'hFFFF_FFFF);
        wr(8'h84, 32'hFFFF_FFFF);
        wr(8'hF0, 32'hFFFF_FFFF);
        wr(8'h01, 32'h0000_0000);
        rd_chk("R5 hole read",      8'h80, 32'h0);
        rd_chk("R5 hole end read",  8'h8C, 32'h0);
        rd_chk("R5 past map read",  8'hF0, 32'h0);
        rd_chk("R5 misaligned read", 8'h05, 32'h0);
        look("R5 win0 untouched", 36'h1_234A_BCDE, 1, 4'h3, 8'hA5, 36'h1_234A_BCDE, 0);
        look("R5 overlap untouched", 36'h0_8000_1234, 1, 4'h4, 8'hE0, 36'h0_8000_1234, 1);
    endtask

    task automatic t_same_cycle;
        @(negedge clk);
        req_addr  = 36'h0_8000_1234;
        cfg_wr_en = 1'b1;
        cfg_addr  = 8'h30;
        cfg_wdata = 32'h0;
        #1;
        check("R12 old winner before edge", 64'(hit_target), 64'h4);
        check("R12 old multi before edge",  64'(multi_hit),  64'h1);
        @(negedge clk);
        cfg_wr_en = 1'b0;
        #1;
        check("R8 R12 new winner after edge", 64'(hit_target), 64'h7);
        check("R8 R12 no multi after edge",   64'(multi_hit),  64'h0);
    endtask

    task automatic t_disable;
        wr(8'hA0, 32'h0000_0000);
        look("R8 R10 all disabled miss", 36'h0_8000_1234, 0, 0, 0, 0, 0);
        wr(8'h70, 32'h0000_2260);
        rd_chk("R1 R8 ctrl7 enable clear", 8'h70, 32'h0000_2260);
        look("R8 win7 disabled", 36'h0_1000_0042, 0, 0, 0, 0, 0);
    endtask

    initial begin : watchdog
        #(5ns * 20000);
        nchk++;
        nfail++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", nchk - nfail, nchk);
        $finish;
    end

    initial begin : main
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_remap_window();
        t_upper_group();
        t_overlap();
        t_hole();
        t_same_cycle();
        t_disable();
        $display("%0d/%0d checks passed", nchk - nfail, nchk);
        $finish;
    end

endmodule